// File: doc/BRIEF.md
# Per-Channel Frame-Sync Slot Assigner

This block drives the frame-sync strobes for four codec channels that share a time-division bus. Each channel has one transmit strobe and one receive strobe. Any of these eight strobes can be placed in any of 64 eight-bit slots of a frame. A strobe is high for the eight bit-clock cycles of its slot, and only once a valid slot has been programmed for it. The block also drives a shared active-low flag that is low while any transmit strobe is high.

Slots are programmed through a slow three-wire serial port: a data line, a shift clock and an active-low select. Each word is eight bits. Its two top bits choose the direction, and the six low bits give the slot number. Two parallel channel-select pins name the channel the word applies to. All three serial lines and the select pins are sampled in the bit-clock domain. A small state machine (`C_IDLE`, `C_SHIFT`, `C_COMMIT`) frames each word. In `C_IDLE`, when select is seen low, the channel is captured, the bit counter is cleared and the machine moves to `C_SHIFT`. In `C_SHIFT`, each rising edge of the shift clock shifts in one bit, and when select is seen high the machine moves to `C_COMMIT`. `C_COMMIT` lasts one cycle. It passes the word on only if exactly eight bits arrived, then returns to `C_IDLE`.

An accepted word goes into a staged table for each direction. The live table that drives the comparators takes the staged values at the next frame-start pulse of that direction. A frame-start pulse also restarts that direction's slot counter.

Top module: `slot_sync_assigner`

## Requirements
- R1: After reset, all eight strobes are low and `tsx_n` is high. Every assignment is invalid, and both slot counters hold at position 0 until their first frame-start pulse.
- R2: The bit position of a direction runs 0..511. The slot number is the position divided by 8. After 511 the position wraps to 0 with no new frame-start pulse, and each strobe repeats its 8-cycle window every 512 cycles.
- R3: Suppose a frame-start input is sampled high at bit-clock edge E. Then a strobe that holds a valid slot s is high in exactly the 8 cycles that follow edges E+8s through E+8s+7, and low in all other cycles.
- R4: A word is 8 bits. Bits are taken on rising edges of `ctl_clk` while `ctl_sel_n` is low, most significant bit first. Bit 7 is the transmit-select bit X, bit 6 is the receive-select bit R, and bits 5:0 are the slot. The word is accepted when `ctl_sel_n` returns high. Shift-clock edges while select is high are ignored.
- R5: The X,R pair chooses what is updated. 1,0 updates the transmit strobe. 0,1 updates the receive strobe. 1,1 updates both, to the same slot. 0,0 makes both strobes of the channel invalid, so they stay low.
- R6: The word applies to the channel on `ch_sel` when select goes low (0 = `fsx[0]`/`fsr[0]`, and so on). A change of `ch_sel` during the word has no effect.
- R7: A word with fewer or more than 8 clock edges is discarded, and no assignment changes.
- R8: An accepted word changes the live strobe timing only at the next frame-start pulse of the direction it updates. A frame-start pulse of the other direction does not apply it.
- R9: `tsx_n` is low in exactly the cycles in which at least one transmit strobe is high. Several transmit strobes may share a slot.
- R10: A frame-start pulse in the middle of a frame restarts that direction at position 0 at once, which allows frames shorter than 64 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fs | input | 1 | Transmit frame-start pulse, one bit clock wide, marks slot 0 |
| rx_fs | input | 1 | Receive frame-start pulse, one bit clock wide, marks slot 0 |
| ctl_clk | input | 1 | Serial shift clock; each level held at least 3 bit clocks |
| ctl_sel_n | input | 1 | Active-low word select |
| ctl_data | input | 1 | Serial data, stable around each rising shift-clock edge |
| ch_sel | input | 2 | Channel the next word applies to |
| fsx | output | 4 | Transmit frame-sync strobes, one per channel |
| fsr | output | 4 | Receive frame-sync strobes, one per channel |
| tsx_n | output | 1 | Low while any transmit strobe is high |

## Verification
A corrupted slot counter moves every strobe of that direction to the wrong cycles. This shows within one frame of 512 bit clocks. A slip that happens after the frame start shows on the next occupied slot. A fault in the staged or live tables stays hidden until the next frame-start pulse of that direction, and then appears as a strobe in the wrong slot or a missing strobe for a whole frame. A fault in the word-framing machine, such as an off-by-one bit count or a channel taken at the wrong time, shows one frame start after the faulty word. The transmit-activity flag is compared with the strobes in every cycle, so any disagreement shows at once.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    // states of the serial word receiver
    typedef enum logic [1:0] {
        C_IDLE   = 2'd0,
        C_SHIFT  = 2'd1,
        C_COMMIT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/tsa_ctl_rx.sv
module tsa_ctl_rx
    import tsa_pkg::*;
#(
    parameter int CH_W   = 2,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_clk,
    input  logic              ctl_sel_n,
    input  logic              ctl_data,
    input  logic [CH_W-1:0]   ch_sel,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic [CH_W-1:0]   word_chan
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    // two-stage samplers into the bit-clock domain
    logic [1:0] clk_sync, sel_sync, dat_sync;
    logic       clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sync <= '0;
            sel_sync <= '1;
            dat_sync <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sync <= {clk_sync[0], ctl_clk};
            sel_sync <= {sel_sync[0], ctl_sel_n};
            dat_sync <= {dat_sync[0], ctl_data};
            clk_prev <= clk_sync[1];
        end
    end

    logic clk_rise, sel_high;
    assign clk_rise = clk_sync[1] & ~clk_prev;
    assign sel_high = sel_sync[1];

    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:   if (!sel_high) state_d = C_SHIFT;
            C_SHIFT:  if (sel_high)  state_d = C_COMMIT;
            C_COMMIT: state_d = C_IDLE;
            default:  state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    // word datapath
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CH_W-1:0]   chan_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            chan_q  <= '0;
        end else if (state_q == C_IDLE && !sel_high) begin
            chan_q <= ch_sel;
            cnt_q  <= '0;
        end else if (state_q == C_SHIFT && !sel_high && clk_rise) begin
            shreg_q <= {shreg_q[WORD_W-2:0], dat_sync[1]};
            if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        word_valid = (state_q == C_COMMIT) && (cnt_q == CNT_FULL);
        word       = shreg_q;
        word_chan  = chan_q;
    end
endmodule

// File: rtl/tsa_dir_engine.sv
module tsa_dir_engine #(
    parameter int CHANNELS = 4,
    parameter int SLOT_W   = 6,
    parameter int BIT_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        upd_valid,
    input  logic [$clog2(CHANNELS)-1:0] upd_chan,
    input  logic                        upd_en,
    input  logic [SLOT_W-1:0]           upd_slot,
    output logic [CHANNELS-1:0]         sync_out,
    output logic                        any_out
);
    localparam int CH_W  = $clog2(CHANNELS);
    localparam int POS_W = SLOT_W + BIT_W;

    logic             running;
    logic [POS_W-1:0] cnt_q, pos;

    // position of the current cycle; a frame start is position 0 itself
    assign pos = frame_start ? '0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (frame_start) begin
            running <= 1'b1;
            cnt_q   <= POS_W'(1);
        end else if (running) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    logic [CHANNELS-1:0] hit;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        logic              stg_en, live_en, eff_en;
        logic [SLOT_W-1:0] stg_slot, live_slot, eff_slot;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_en    <= 1'b0;
                stg_slot  <= '0;
                live_en   <= 1'b0;
                live_slot <= '0;
            end else begin
                if (frame_start) begin
                    live_en   <= stg_en;
                    live_slot <= stg_slot;
                end
                if (upd_valid && upd_chan == CH_W'(g)) begin
                    stg_en   <= upd_en;
                    stg_slot <= upd_slot;
                end
            end
        end

        assign eff_en   = frame_start ? stg_en   : live_en;
        assign eff_slot = frame_start ? stg_slot : live_slot;
        assign hit[g]   = eff_en && (pos[POS_W-1:BIT_W] == eff_slot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_out <= '0;
            any_out  <= 1'b0;
        end else begin
            sync_out <= hit;
            any_out  <= |hit;
        end
    end
endmodule

// File: rtl/slot_sync_assigner.sv
module slot_sync_assigner #(
    parameter int CHANNELS      = 4,
    parameter int SLOTS         = 64,
    parameter int BITS_PER_SLOT = 8
) (
    input  logic                        bclk,
    input  logic                        rst_n,
    input  logic                        tx_fs,
    input  logic                        rx_fs,
    input  logic                        ctl_clk,
    input  logic                        ctl_sel_n,
    input  logic                        ctl_data,
    input  logic [$clog2(CHANNELS)-1:0] ch_sel,
    output logic [CHANNELS-1:0]         fsx,
    output logic [CHANNELS-1:0]         fsr,
    output logic                        tsx_n
);
    localparam int CH_W   = $clog2(CHANNELS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BITS_PER_SLOT);
    localparam int WORD_W = SLOT_W + 2;

    logic              word_valid;
    logic [WORD_W-1:0] word;
    logic [CH_W-1:0]   word_chan;

    tsa_ctl_rx #(.CH_W(CH_W), .WORD_W(WORD_W)) u_ctl (
        .clk        (bclk),
        .rst_n      (rst_n),
        .ctl_clk    (ctl_clk),
        .ctl_sel_n  (ctl_sel_n),
        .ctl_data   (ctl_data),
        .ch_sel     (ch_sel),
        .word_valid (word_valid),
        .word       (word),
        .word_chan  (word_chan)
    );

    // direction decode: X,R = 00 invalidates both, otherwise selected ones load
    logic sel_x, sel_r, upd_tx, upd_rx, upd_en;
    assign sel_x  = word[WORD_W-1];
    assign sel_r  = word[WORD_W-2];
    assign upd_tx = word_valid && (sel_x || !sel_r);
    assign upd_rx = word_valid && (sel_r || !sel_x);
    assign upd_en = sel_x | sel_r;

    logic tx_any, rx_any;

    tsa_dir_engine #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_tx (
        .clk         (bclk),
        .rst_n       (rst_n),
        .frame_start (tx_fs),
        .upd_valid   (upd_tx),
        .upd_chan    (word_chan),
        .upd_en      (upd_en),
        .upd_slot    (word[SLOT_W-1:0]),
        .sync_out    (fsx),
        .any_out     (tx_any)
    );

    tsa_dir_engine #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_rx (
        .clk         (bclk),
        .rst_n       (rst_n),
        .frame_start (rx_fs),
        .upd_valid   (upd_rx),
        .upd_chan    (word_chan),
        .upd_en      (upd_en),
        .upd_slot    (word[SLOT_W-1:0]),
        .sync_out    (fsr),
        .any_out     (rx_any)
    );

    logic rx_any_unused;
    assign rx_any_unused = rx_any;
    assign tsx_n = ~tx_any;
endmodule

// File: rtl/slot_sync_assigner_chk.sv
module slot_sync_assigner_chk #(
    parameter int CHANNELS = 4
) (
    input logic                bclk,
    input logic                rst_n,
    input logic                tx_fs,
    input logic                rx_fs,
    input logic [CHANNELS-1:0] fsx,
    input logic [CHANNELS-1:0] fsr,
    input logic                tsx_n
);
    logic seen_fs;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) seen_fs <= 1'b0;
        else if (tx_fs || rx_fs) seen_fs <= 1'b1;
    end

    assert_quiet_before_frame_R1: assert property (@(posedge bclk) disable iff (!rst_n)
        !seen_fs |-> (fsx == '0 && fsr == '0));

    assert_tsx_active_R9: assert property (@(posedge bclk) disable iff (!rst_n)
        (|fsx) |-> !tsx_n);

    assert_tsx_idle_R9: assert property (@(posedge bclk) disable iff (!rst_n)
        (fsx == '0) |-> tsx_n);

    for (genvar g = 0; g < CHANNELS; g++) begin : g_len
        logic [3:0] run_x, run_r;

        always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n) begin
                run_x <= '0;
                run_r <= '0;
            end else begin
                if (tx_fs)       run_x <= '0;
                else if (fsx[g]) run_x <= (run_x == 4'hF) ? run_x : run_x + 1'b1;
                else             run_x <= '0;
                if (rx_fs)       run_r <= '0;
                else if (fsr[g]) run_r <= (run_r == 4'hF) ? run_r : run_r + 1'b1;
                else             run_r <= '0;
            end
        end

        assert_tx_window_len_R2: assert property (@(posedge bclk) disable iff (!rst_n)
            run_x <= 4'd8);

        assert_rx_window_len_R2: assert property (@(posedge bclk) disable iff (!rst_n)
            run_r <= 4'd8);
    end
endmodule

bind slot_sync_assigner slot_sync_assigner_chk #(.CHANNELS(CHANNELS)) u_chk (
    .bclk  (bclk),
    .rst_n (rst_n),
    .tx_fs (tx_fs),
    .rx_fs (rx_fs),
    .fsx   (fsx),
    .fsr   (fsr),
    .tsx_n (tsx_n)
);

// File: tb/slot_sync_assigner_tb.sv
module slot_sync_assigner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int FRAME      = 512;
    localparam int HALF       = 4;

    logic       bclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_fs = 1'b0, rx_fs = 1'b0;
    logic       ctl_clk = 1'b0, ctl_sel_n = 1'b1, ctl_data = 1'b0;
    logic [1:0] ch_sel = 2'd0;
    logic [3:0] fsx, fsr;
    logic       tsx_n;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    slot_sync_assigner u_dut (
        .bclk(bclk), .rst_n(rst_n), .tx_fs(tx_fs), .rx_fs(rx_fs),
        .ctl_clk(ctl_clk), .ctl_sel_n(ctl_sel_n), .ctl_data(ctl_data),
        .ch_sel(ch_sel), .fsx(fsx), .fsr(fsr), .tsx_n(tsx_n)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R1";

    // bench model: index 0 = transmit, 1 = receive
    int unsigned m_cnt [2];
    bit          m_run [2];
    bit          s_en  [2][NCH];
    int          s_slot[2][NCH];
    bit          l_en  [2][NCH];
    int          l_slot[2][NCH];
    logic [3:0]  exp_x = '0, exp_r = '0;

    task automatic model_edge(input bit tf, input bit rf);
        for (int d = 0; d < 2; d++) begin
            bit fs;
            int unsigned pos;
            logic [3:0] e;
            fs  = (d == 0) ? tf : rf;
            pos = fs ? 0 : m_cnt[d];
            if (fs)
                for (int c = 0; c < NCH; c++) begin
                    l_en[d][c]   = s_en[d][c];
                    l_slot[d][c] = s_slot[d][c];
                end
            for (int c = 0; c < NCH; c++)
                e[c] = l_en[d][c] && (int'(pos / 8) == l_slot[d][c]);
            if (d == 0) exp_x = e; else exp_r = e;
            if (fs) begin
                m_run[d] = 1'b1;
                m_cnt[d] = 1;
            end else if (m_run[d]) begin
                m_cnt[d] = (m_cnt[d] + 1) % FRAME;
            end
        end
    endtask

    task automatic compare();
        logic [8:0] got, exp;
        got = {tsx_n, fsr, fsx};
        exp = {~|exp_x, exp_r, exp_x};
        checks++;
        if (got !== exp) begin
            failures++;
            if (got[8] !== exp[8])
                $display("FAIL R9 tsx_n actual=%b expected=%b at %0t", got[8], exp[8], $time);
            else
                $display("FAIL %s fsr/fsx actual=%b expected=%b at %0t", cur_tag, got[7:0], exp[7:0], $time);
        end
    endtask

    // one bit clock: inputs driven at the falling edge, outputs compared at the next falling edge
    task automatic step(input bit tf, input bit rf);
        tx_fs = tf;
        rx_fs = rf;
        @(posedge bclk);
        model_edge(tf, rf);
        @(negedge bclk);
        tx_fs = 1'b0;
        rx_fs = 1'b0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic run_frame(input bit tf, input bit rf);
        step(tf, rf);
        idle(FRAME - 1);
    endtask

    task automatic send_word(input int chan, input bit x, input bit r, input int slot,
                             input int nbits, input bit swap_ch);
        logic [7:0] w;
        w = {x, r, 6'(slot)};
        ch_sel = 2'(chan);
        ctl_sel_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            ctl_data = (i < 8) ? w[7-i] : 1'b0;
            ctl_clk = 1'b0;
            idle(HALF);
            ctl_clk = 1'b1;
            idle(HALF);
            if (swap_ch && i == 2) ch_sel = ~2'(chan);
        end
        ctl_clk = 1'b0;
        idle(HALF);
        ctl_sel_n = 1'b1;
        idle(2 * HALF);
        ch_sel = 2'(chan);
        if (nbits == 8) begin
            if (x || !r) begin s_en[0][chan] = x | r; s_slot[0][chan] = slot; end
            if (r || !x) begin s_en[1][chan] = x | r; s_slot[1][chan] = slot; end
        end
    endtask

    bit done = 1'b0;

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_cnt[d] = 0;
            m_run[d] = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                s_en[d][c] = 1'b0; s_slot[d][c] = 0;
                l_en[d][c] = 1'b0; l_slot[d][c] = 0;
            end
        end
        repeat (3) @(negedge bclk);
        // R1: state during reset
        cur_tag = "R1";
        compare();
        rst_n = 1'b1;
        // R1: quiet and holding before any frame start
        idle(40);

        // R8 / R3: word before the first frame start stays staged, then appears
        cur_tag = "R8";
        send_word(0, 1'b1, 1'b0, 5, 8, 1'b0);
        idle(20);
        cur_tag = "R3";
        run_frame(1'b1, 1'b1);

        // R4: sweep of all eight strobes over several slot layouts incl. slots 0 and 63
        cur_tag = "R4";
        for (int b = 0; b < 4; b++) begin
            int base;
            base = b * 21;
            for (int c = 0; c < NCH; c++) begin
                send_word(c, 1'b1, 1'b0, (base + 9 * c) % 64, 8, 1'b0);
                send_word(c, 1'b0, 1'b1, (base + 63 - 7 * c) % 64, 8, 1'b0);
            end
            run_frame(1'b1, 1'b1);
        end

        // R2: free-running wrap without a new frame start
        cur_tag = "R2";
        idle(FRAME);

        // R9: shared slots on the transmit side
        cur_tag = "R9";
        send_word(1, 1'b1, 1'b0, 10, 8, 1'b0);
        send_word(3, 1'b1, 1'b0, 10, 8, 1'b0);
        send_word(2, 1'b1, 1'b0, 11, 8, 1'b0);
        run_frame(1'b1, 1'b1);

        // R5: both-direction load and invalidate
        cur_tag = "R5";
        send_word(2, 1'b1, 1'b1, 30, 8, 1'b0);
        send_word(0, 1'b0, 1'b0, 0, 8, 1'b0);
        run_frame(1'b1, 1'b1);

        // R7: short and long words discarded
        cur_tag = "R7";
        send_word(1, 1'b1, 1'b1, 50, 7, 1'b0);
        send_word(1, 1'b1, 1'b1, 51, 9, 1'b0);
        run_frame(1'b1, 1'b1);

        // R6: channel captured at select fall
        cur_tag = "R6";
        send_word(3, 1'b1, 1'b1, 44, 8, 1'b1);
        run_frame(1'b1, 1'b1);

        // R8: per-direction application
        cur_tag = "R8";
        send_word(1, 1'b0, 1'b1, 40, 8, 1'b0);
        send_word(0, 1'b1, 1'b0, 41, 8, 1'b0);
        run_frame(1'b1, 1'b0);
        run_frame(1'b0, 1'b1);

        // R10: early frame restart
        cur_tag = "R10";
        step(1'b1, 1'b1);
        idle(100);
        run_frame(1'b1, 1'b0);
        idle(90);
        run_frame(1'b0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge bclk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule